// File: doc/BRIEF.md
# Keyed Watchdog Arming Sequencer

This unit guards the watchdog function of a 64-bit timer. Software arms it by writing two fixed 16-bit keys, in order, into one control word, each with the enable flag set. Once it is armed, the same two keys written back to back service the watchdog and produce a one-cycle pulse that clears the external 64-bit counter. A write that carries any other key, or a timeout reported by the counter, raises a system reset request. The request holds until the next system reset.

The unit reacts only while the global timer mode input selects watchdog operation. In any other mode it ignores control writes and timeouts. The counter, the period comparison and the bus decode sit outside this block. The block receives one write strobe with its data word and one timeout flag.

Top module: `wdog_key_seq`

## Requirements
- R1: After a synchronous active-low reset, `wd_phase` is 0 (idle), and `wd_en`, `cnt_clear` and `sys_rst_req` are all 0.
- R2: In idle, a write whose key field (bits 31:16) equals 0xA5C6 and whose enable flag (bit 14) is 1 moves `wd_phase` to 1 (pre-active). The same key with the enable flag at 0 leaves the unit idle.
- R3: In pre-active, a write with key 0xDA7E and the enable flag set moves `wd_phase` to 2 (active).
- R4: In idle or pre-active, a write whose key is neither 0xA5C6 nor 0xDA7E leaves `wd_phase` unchanged. The same holds for key 0xDA7E written in idle.
- R5: In active, a write with any key other than 0xA5C6 sets `sys_rst_req`. After 0xA5C6 (`wd_phase` 3, service half done), any key other than 0xA5C6 or 0xDA7E also sets it.
- R6: In phase 3, a write with key 0xDA7E returns `wd_phase` to 2 and drives `cnt_clear` high for exactly one cycle, with no reset request.
- R7: `cnt_timeout` sets `sys_rst_req` in phases 2 and 3 and has no effect in phases 0 and 1.
- R8: `sys_rst_req` stays high until reset. While it is high, the phase is frozen and `cnt_clear` stays 0.
- R9: While `mode_sel` differs from 2, writes and timeouts change neither `wd_phase`, `cnt_clear` nor `sys_rst_req`.
- R10: `wd_en` is 1 in every phase except idle. In phases 2 and 3, a valid service key written with the enable flag at 0 still advances the sequence, and `wd_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Global timer mode; 2 selects watchdog operation |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word: key in 31:16, enable flag in bit 14 |
| cnt_timeout | input | 1 | Counter reached its 64-bit period |
| wd_phase | output | 2 | 0 idle, 1 pre-active, 2 active, 3 active with first service key seen |
| wd_en | output | 1 | Enable flag as held by the unit |
| cnt_clear | output | 1 | One-cycle pulse that clears the 64-bit counter |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
Every result is registered, so the effect of a write or timeout sampled at one rising edge shows on the ports right after that edge and is due exactly one cycle later. The bench drives inputs on falling edges and updates its behavioural model on the rising edge from the same inputs. It compares phase, enable, clear pulse and reset request on the following falling edge, so model and design are always compared for the same cycle. Directed checks after each write sample at that same falling edge. The one-cycle width of the clear pulse is also checked on the falling edge after it.

// File: rtl/wdk_pkg.sv
// Package: shared phase encoding for the keyed watchdog sequencer.
// Assumes a 2-bit phase whose values are visible at the top-level port.
package wdk_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_PRE  = 2'd1,
        WD_LIVE = 2'd2,
        WD_HALF = 2'd3
    } wd_phase_e;
endpackage

// File: rtl/wdk_decode.sv
// Module: wdk_decode
// Classifies a control write by its key field and gates every event with
// the watchdog mode and the halted (reset requested) condition.
// Assumes the write word and the timeout flag are already synchronous.
module wdk_decode #(
    parameter int          DATA_W    = 32,
    parameter int          KEY_W     = 16,
    parameter int          KEY_LSB   = 16,
    parameter int          EN_BIT    = 14,
    parameter int          MODE_W    = 2,
    parameter int unsigned WDOG_MODE = 2,
    parameter logic [15:0] KEY_ARM   = 16'hA5C6,
    parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              timeout,
    input  logic              halted,
    output logic              hit_arm,
    output logic              hit_go,
    output logic              hit_other,
    output logic              en_flag,
    output logic              tmo
);
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    logic             live;
    logic [KEY_W-1:0] key;

    // Purpose: decide whether the unit listens at all this cycle.
    always_comb begin
        live = (mode == MODE_W'(WDOG_MODE)) && !halted;
    end

    // Purpose: split the write into key classes and the enable flag.
    always_comb begin
        key       = wr_data[KEY_MSB:KEY_LSB];
        en_flag   = wr_data[EN_BIT];
        hit_arm   = live && wr_en && (key == KEY_W'(KEY_ARM));
        hit_go    = live && wr_en && (key == KEY_W'(KEY_GO));
        hit_other = live && wr_en && !(key == KEY_W'(KEY_ARM)) && !(key == KEY_W'(KEY_GO));
        tmo       = live && timeout;
    end
endmodule

// File: rtl/wdk_fsm.sv
// Module: wdk_fsm
// Phase sequencer: idle -> pre-active -> active, then alternating service
// halves. Flags a wrong key in the active phases and a completed service.
// Assumes the hit inputs are already gated by mode and halt.
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit_arm,
    input  logic      hit_go,
    input  logic      hit_other,
    input  logic      en_flag,
    output wd_phase_e phase,
    output logic      bad_key,
    output logic      svc_done,
    output logic      guarding
);
    wd_phase_e phase_nx;

    // Purpose: compute the next phase from the classified write.
    always_comb begin
        phase_nx = phase;
        case (phase)
            WD_IDLE: if (hit_arm && en_flag) phase_nx = WD_PRE;
            WD_PRE:  if (hit_go && en_flag)  phase_nx = WD_LIVE;
            WD_LIVE: if (hit_arm)            phase_nx = WD_HALF;
            WD_HALF: if (hit_go)             phase_nx = WD_LIVE;
            default: phase_nx = WD_IDLE;
        endcase
    end

    // Purpose: flag wrong keys and completed service sequences.
    always_comb begin
        guarding = (phase == WD_LIVE) || (phase == WD_HALF);
        bad_key  = ((phase == WD_LIVE) && (hit_go || hit_other)) ||
                   ((phase == WD_HALF) && hit_other);
        svc_done = (phase == WD_HALF) && hit_go;
    end

    // Purpose: hold the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= WD_IDLE;
        else        phase <= phase_nx;
    end
endmodule

// File: rtl/wdk_trip.sv
// Module: wdk_trip
// Holds the sticky reset request and registers the one-cycle counter clear.
// Assumes its event inputs are already gated by mode and halt.
module wdk_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_key,
    input  logic tmo,
    input  logic guarding,
    input  logic svc_done,
    output logic rst_req,
    output logic clr_pulse
);
    // Purpose: latch a reset request until system reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rst_req <= 1'b0;
        else if (bad_key || (tmo && guarding))  rst_req <= 1'b1;
    end

    // Purpose: emit the counter clear one cycle after service completes.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_pulse <= 1'b0;
        else        clr_pulse <= svc_done;
    end
endmodule

// File: rtl/wdog_key_seq.sv
// Module: wdog_key_seq (top)
// Keyed arming and service sequencer for a 64-bit watchdog timer. Every
// output is registered or decoded from registers and reacts one cycle
// after the write or timeout. Assumes a single control word write port.
module wdog_key_seq
    import wdk_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          KEY_W     = 16,
    parameter int          KEY_LSB   = 16,
    parameter int          EN_BIT    = 14,
    parameter int          MODE_W    = 2,
    parameter int unsigned WDOG_MODE = 2,
    parameter logic [15:0] KEY_ARM   = 16'hA5C6,
    parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              cnt_timeout,
    output logic [1:0]        wd_phase,
    output logic              wd_en,
    output logic              cnt_clear,
    output logic              sys_rst_req
);
    logic      hit_arm, hit_go, hit_other, en_flag, tmo;
    logic      bad_key, svc_done, guarding;
    wd_phase_e phase;

    wdk_decode #(
        .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .EN_BIT(EN_BIT),
        .MODE_W(MODE_W), .WDOG_MODE(WDOG_MODE),
        .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)
    ) u_decode (
        .wr_en    (ctl_we),
        .wr_data  (ctl_wdata),
        .mode     (mode_sel),
        .timeout  (cnt_timeout),
        .halted   (sys_rst_req),
        .hit_arm  (hit_arm),
        .hit_go   (hit_go),
        .hit_other(hit_other),
        .en_flag  (en_flag),
        .tmo      (tmo)
    );

    wdk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_arm  (hit_arm),
        .hit_go   (hit_go),
        .hit_other(hit_other),
        .en_flag  (en_flag),
        .phase    (phase),
        .bad_key  (bad_key),
        .svc_done (svc_done),
        .guarding (guarding)
    );

    wdk_trip u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .bad_key  (bad_key),
        .tmo      (tmo),
        .guarding (guarding),
        .svc_done (svc_done),
        .rst_req  (sys_rst_req),
        .clr_pulse(cnt_clear)
    );

    // Purpose: expose the phase and the held enable flag.
    always_comb begin
        wd_phase = phase;
        wd_en    = (phase != WD_IDLE);
    end
endmodule

// File: rtl/wdk_checker.sv
// Module: wdk_checker
// Temporal properties of the sequencer, attached to the top through bind.
// Assumes it sees only the top-level ports.
module wdk_checker #(
    parameter int          DATA_W    = 32,
    parameter int          KEY_W     = 16,
    parameter int          KEY_LSB   = 16,
    parameter int          EN_BIT    = 14,
    parameter int          MODE_W    = 2,
    parameter int unsigned WDOG_MODE = 2,
    parameter logic [15:0] KEY_ARM   = 16'hA5C6,
    parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_sel,
    input logic              ctl_we,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              cnt_timeout,
    input logic [1:0]        wd_phase,
    input logic              wd_en,
    input logic              cnt_clear,
    input logic              sys_rst_req
);
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    logic [KEY_W-1:0] key;
    logic             mode_ok, is_arm, is_go, en;

    // Purpose: decode the observed write for the properties below.
    always_comb begin
        key     = ctl_wdata[KEY_MSB:KEY_LSB];
        en      = ctl_wdata[EN_BIT];
        mode_ok = (mode_sel == MODE_W'(WDOG_MODE));
        is_arm  = (key == KEY_W'(KEY_ARM));
        is_go   = (key == KEY_W'(KEY_GO));
    end

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_phase == 2'd0 && ctl_we && mode_ok && !sys_rst_req && is_arm && en) |=> (wd_phase == 2'd1));

    a_r3_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_phase == 2'd1 && ctl_we && mode_ok && !sys_rst_req && is_go && en) |=> (wd_phase == 2'd2));

    a_r4_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_phase[1] && ctl_we && !is_arm && !is_go) |=> $stable(wd_phase));

    a_r5_wrong_key_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_phase == 2'd2 && ctl_we && mode_ok && !is_arm) |=> sys_rst_req);

    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> !cnt_clear);

    a_r6_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |-> (wd_phase == 2'd2));

    a_r7_timeout_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_phase[1] && cnt_timeout && mode_ok) |=> sys_rst_req);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (sys_rst_req && $stable(wd_phase) && !cnt_clear));

    a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ok && !sys_rst_req) |=> ($stable(wd_phase) && !sys_rst_req && !cnt_clear));

    a_r10_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
        wd_phase[1] |-> wd_en);
endmodule

bind wdog_key_seq wdk_checker #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .EN_BIT(EN_BIT),
    .MODE_W(MODE_W), .WDOG_MODE(WDOG_MODE), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .cnt_timeout(cnt_timeout), .wd_phase(wd_phase),
    .wd_en(wd_en), .cnt_clear(cnt_clear), .sys_rst_req(sys_rst_req)
);

// File: tb/wdog_key_seq_test.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks tagged with their requirement.
module wdog_key_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd2;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = 32'd0;
    logic        cnt_timeout = 1'b0;
    logic [1:0]  wd_phase;
    logic        wd_en, cnt_clear, sys_rst_req;

    int    n_run = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    comparing = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_phase = 0;
    bit m_req = 1'b0;
    bit m_clr = 1'b0;

    always #2.5 clk = ~clk;

    wdog_key_seq uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .cnt_timeout(cnt_timeout), .wd_phase(wd_phase),
        .wd_en(wd_en), .cnt_clear(cnt_clear), .sys_rst_req(sys_rst_req)
    );

    // Reference model: advances on the rising edge from the held inputs.
    always @(posedge clk) begin
        int  k;
        bit  e;
        k = int'(ctl_wdata[31:16]);
        e = ctl_wdata[14];
        if (!rst_n) begin
            m_phase <= 0; m_req <= 1'b0; m_clr <= 1'b0;
        end else begin
            m_clr <= 1'b0;
            if (mode_sel == 2'd2 && !m_req) begin
                if (cnt_timeout && m_phase >= 2) m_req <= 1'b1;
                if (ctl_we) begin
                    if (m_phase == 0 && k == 'hA5C6 && e) m_phase <= 1;
                    else if (m_phase == 1 && k == 'hDA7E && e) m_phase <= 2;
                    else if (m_phase == 2) begin
                        if (k == 'hA5C6) m_phase <= 3;
                        else m_req <= 1'b1;
                    end else if (m_phase == 3) begin
                        if (k == 'hDA7E) begin m_phase <= 2; m_clr <= 1'b1; end
                        else if (k != 'hA5C6) m_req <= 1'b1;
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (comparing && !done) begin
            n_run++;
            if (wd_phase !== 2'(m_phase) || wd_en !== (m_phase != 0) ||
                cnt_clear !== m_clr || sys_rst_req !== m_req) begin
                n_fail++;
                $display("FAIL %s cycle %0d: got phase=%0d en=%b clr=%b req=%b, expected phase=%0d en=%b clr=%b req=%b",
                         cur_req, cycles, wd_phase, wd_en, cnt_clear, sys_rst_req,
                         m_phase, (m_phase != 0), m_clr, m_req);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [1:0] ph, input bit req_o, input bit clr);
        n_run++;
        if (wd_phase !== ph || sys_rst_req !== req_o || cnt_clear !== clr) begin
            n_fail++;
            $display("FAIL %s: got phase=%0d req=%b clr=%b, expected phase=%0d req=%b clr=%b",
                     req, wd_phase, sys_rst_req, cnt_clear, ph, req_o, clr);
        end
    endtask

    task automatic wr(input logic [15:0] key, input bit en);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {key, 1'b0, en, 14'h0};
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = 32'd0;
    endtask

    task automatic tmo();
        @(negedge clk); cnt_timeout = 1'b1;
        @(negedge clk); cnt_timeout = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic arm();
        wr(16'hA5C6, 1'b1);
        wr(16'hDA7E, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        comparing = 1'b1;
        cur_req = "R1";
        chk("R1", 2'd0, 1'b0, 1'b0);

        cur_req = "R2"; wr(16'hA5C6, 1'b0); chk("R2", 2'd0, 1'b0, 1'b0);
        cur_req = "R4"; wr(16'hDA7E, 1'b1); chk("R4", 2'd0, 1'b0, 1'b0);
        cur_req = "R2"; wr(16'hA5C6, 1'b1); chk("R2", 2'd1, 1'b0, 1'b0);
        cur_req = "R4"; wr(16'h1234, 1'b1); chk("R4", 2'd1, 1'b0, 1'b0);
        cur_req = "R7"; tmo();              chk("R7", 2'd1, 1'b0, 1'b0);
        cur_req = "R3"; wr(16'hDA7E, 1'b1); chk("R3", 2'd2, 1'b0, 1'b0);

        cur_req = "R10"; wr(16'hA5C6, 1'b0); chk("R10", 2'd3, 1'b0, 1'b0);
        n_run++;
        if (wd_en !== 1'b1) begin
            n_fail++;
            $display("FAIL R10: got wd_en=%b, expected 1", wd_en);
        end
        cur_req = "R6"; wr(16'hDA7E, 1'b0); chk("R6", 2'd2, 1'b0, 1'b1);
        @(negedge clk); chk("R6", 2'd2, 1'b0, 1'b0);

        cur_req = "R9"; mode_sel = 2'd1;
        wr(16'h0000, 1'b1); tmo(); wr(16'hDA7E, 1'b1);
        chk("R9", 2'd2, 1'b0, 1'b0);
        mode_sel = 2'd2;

        cur_req = "R7"; tmo(); chk("R7", 2'd2, 1'b1, 1'b0);
        cur_req = "R8"; wr(16'hA5C6, 1'b1); wr(16'hDA7E, 1'b1);
        repeat (4) @(negedge clk);
        chk("R8", 2'd2, 1'b1, 1'b0);
        cur_req = "R1"; do_reset(); chk("R1", 2'd0, 1'b0, 1'b0);

        cur_req = "R5"; arm(); wr(16'h0000, 1'b1); chk("R5", 2'd2, 1'b1, 1'b0);
        do_reset();
        arm(); wr(16'hA5C6, 1'b1); wr(16'hBEEF, 1'b1); chk("R5", 2'd3, 1'b1, 1'b0);
        do_reset();
        arm(); wr(16'hDA7E, 1'b1); chk("R5", 2'd2, 1'b1, 1'b0);
        do_reset();

        cur_req = "R6"; arm();
        for (int i = 0; i < 3; i++) begin
            wr(16'hA5C6, 1'b1); wr(16'hA5C6, 1'b1); wr(16'hDA7E, 1'b1);
            chk("R6", 2'd2, 1'b0, 1'b1);
        end
        cur_req = "R7"; tmo(); chk("R7", 2'd2, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule